// File: doc/BRIEF.md
# Single-Bus Fetch and Direct-Load Control Sequencer

This block is the hardwired control unit of a small processor built around one shared data bus. A step counter walks through a fixed sequence of control steps. In each step the block raises the register-transfer strobes that move one value across the bus. These strobes are a bus-drive enable for each source register and a load enable for each destination register, plus a memory read request, an increment select for the adder in front of the Z temporary register, and an end strobe. The sequence fetches an instruction. If the opcode names the direct load, it then reads the word at the address field of the instruction into register R1.

Memory answers each read with a one-cycle completion pulse. The block waits for that pulse in two steps: the step that writes the incremented program counter back, and the step that waits for the operand. During a wait the block raises no strobe at all, so nothing is loaded while memory is still busy. An opcode the block does not know ends the instruction in the decode step, and the next fetch follows at once. The registers, the bus and the memory are outside the block.

Top module: `fetch_step_ctrl`

## Requirements
- R1: While `rst_n` is low, every output strobe is low. In the first cycle after reset is released, every strobe is also low. The fetch step follows in the next cycle.
- R2: Fetch step: `pc_oe`, `mar_ie`, `mem_rd`, `alu_inc` and `z_ie` are high, so the program counter goes to the address register and Z takes the program counter plus one. All other strobes are low.
- R3: Counter write-back step: when `mem_done` is high, `z_oe` and `pc_ie` are high and the sequence moves on. No other strobe is high.
- R4: Instruction load step: `mdr_oe` and `ir_ie` are high and the step takes one cycle.
- R5: Decode step with `opcode` equal to LOAD_CODE (default 4'h1): `ir_oe` drives the address field onto the bus, and `mar_ie` and `mem_rd` are high.
- R6: Operand steps: after a wait step in which memory completes, the next step raises `mdr_oe`, `r1_ie` and `end_step` together, so R1 takes the data that was read.
- R7: Decode step with any other opcode: only `end_step` is high. R1 is not loaded and the program counter keeps its incremented value.
- R8: In the cycle after `end_step`, the fetch step (R2) is active.
- R9: No cycle has more than one of `pc_oe`, `z_oe`, `mdr_oe`, `ir_oe` high.
- R10: In a wait step with `mem_done` low, the step does not advance and every strobe is low.
- R11: A direct load with completion latency L cycles takes 6 + 2L cycles from the fetch step to `end_step` inclusive. An unknown opcode takes 4 + L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_done | input | 1 | One-cycle pulse: the requested memory read has completed |
| opcode | input | OPC_W | Opcode field of the instruction register |
| pc_oe | output | 1 | Program counter drives the bus |
| pc_ie | output | 1 | Program counter loads from the bus |
| mar_ie | output | 1 | Memory address register loads from the bus |
| mdr_oe | output | 1 | Memory data register drives the bus |
| ir_oe | output | 1 | Address field of the instruction register drives the bus |
| ir_ie | output | 1 | Instruction register loads from the bus |
| z_oe | output | 1 | Z temporary register drives the bus |
| z_ie | output | 1 | Z temporary register loads the adder output |
| r1_ie | output | 1 | Register R1 loads from the bus |
| alu_inc | output | 1 | Adder adds one to the bus value |
| mem_rd | output | 1 | Memory read request |
| end_step | output | 1 | Last step of the instruction |

## Verification
The bench compares the strobe vector cycle by cycle with memory latencies of zero, one and three cycles. A design that raised load strobes while memory was busy would write a stale program counter or stale R1 during the stall. A design that advanced without a completion pulse would finish in fewer than 6 + 2L cycles. An unknown opcode is placed between two loads. A design that fell through into the operand steps would overwrite R1, or the following fetch would come late. A reset in the middle of a stall checks that all strobes clear and that fetching starts again at address zero. A bench-side bus model counts any cycle in which two sources drive the bus.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_FETCH     = 3'd1,
    ST_PC_WB     = 3'd2,
    ST_IR_LOAD   = 3'd3,
    ST_DECODE    = 3'd4,
    ST_OPND_WAIT = 3'd5,
    ST_R1_LOAD   = 3'd6
  } step_e;

  typedef struct packed {
    logic pc_oe;
    logic pc_ie;
    logic mar_ie;
    logic mdr_oe;
    logic ir_oe;
    logic ir_ie;
    logic z_oe;
    logic z_ie;
    logic r1_ie;
    logic alu_inc;
    logic mem_rd;
    logic end_step;
  } strobe_t;

endpackage

// File: rtl/fsc_step_counter.sv
module fsc_step_counter
  import fsc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  input  logic  finish,
  output step_e step
);

  step_e step_q;
  step_e step_d;
  logic  step_en;

  always_comb begin
    step_d = step_q;
    if (finish) begin
      step_d = ST_FETCH;
    end else if (advance) begin
      step_d = step_e'(step_q + 3'd1);
    end
  end

  assign step_en = finish | advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  assign step = step_q;

  AST_END_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (step_q == ST_FETCH)); // R8

endmodule

// File: rtl/fsc_strobe_decode.sv
module fsc_strobe_decode
  import fsc_pkg::*;
#(
  parameter int          OPC_W     = 4,
  parameter logic [OPC_W-1:0] LOAD_CODE = OPC_W'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step,
  input  logic             mem_done,
  input  logic [OPC_W-1:0] opcode,
  output strobe_t          strb,
  output logic             advance,
  output logic             finish
);

  logic is_load;
  assign is_load = (opcode == LOAD_CODE);

  always_comb begin
    strb    = '0;
    advance = 1'b0;
    finish  = 1'b0;
    unique case (step)
      ST_IDLE: begin
        advance = 1'b1;
      end
      ST_FETCH: begin
        strb.pc_oe   = 1'b1;
        strb.mar_ie  = 1'b1;
        strb.mem_rd  = 1'b1;
        strb.alu_inc = 1'b1;
        strb.z_ie    = 1'b1;
        advance      = 1'b1;
      end
      ST_PC_WB: begin
        if (mem_done) begin
          strb.z_oe  = 1'b1;
          strb.pc_ie = 1'b1;
          advance    = 1'b1;
        end
      end
      ST_IR_LOAD: begin
        strb.mdr_oe = 1'b1;
        strb.ir_ie  = 1'b1;
        advance     = 1'b1;
      end
      ST_DECODE: begin
        if (is_load) begin
          strb.ir_oe  = 1'b1;
          strb.mar_ie = 1'b1;
          strb.mem_rd = 1'b1;
          advance     = 1'b1;
        end else begin
          strb.end_step = 1'b1;
          finish        = 1'b1;
        end
      end
      ST_OPND_WAIT: begin
        advance = mem_done;
      end
      ST_R1_LOAD: begin
        strb.mdr_oe   = 1'b1;
        strb.r1_ie    = 1'b1;
        strb.end_step = 1'b1;
        finish        = 1'b1;
      end
      default: begin
        finish = 1'b1;
      end
    endcase
  end

  AST_ONE_BUS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({strb.pc_oe, strb.z_oe, strb.mdr_oe, strb.ir_oe}) <= 1); // R9

  AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((step == ST_PC_WB || step == ST_OPND_WAIT) && !mem_done)
      |-> !(strb.pc_ie | strb.mar_ie | strb.ir_ie | strb.z_ie | strb.r1_ie)); // R10

endmodule

// File: rtl/fetch_step_ctrl.sv
module fetch_step_ctrl
  import fsc_pkg::*;
#(
  parameter int               OPC_W     = 4,
  parameter logic [OPC_W-1:0] LOAD_CODE = OPC_W'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_done,
  input  logic [OPC_W-1:0] opcode,
  output logic             pc_oe,
  output logic             pc_ie,
  output logic             mar_ie,
  output logic             mdr_oe,
  output logic             ir_oe,
  output logic             ir_ie,
  output logic             z_oe,
  output logic             z_ie,
  output logic             r1_ie,
  output logic             alu_inc,
  output logic             mem_rd,
  output logic             end_step
);

  step_e   step;
  strobe_t strb;
  logic    advance;
  logic    finish;

  fsc_step_counter i_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .finish  (finish),
    .step    (step)
  );

  fsc_strobe_decode #(
    .OPC_W     (OPC_W),
    .LOAD_CODE (LOAD_CODE)
  ) i_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .mem_done (mem_done),
    .opcode   (opcode),
    .strb     (strb),
    .advance  (advance),
    .finish   (finish)
  );

  assign pc_oe    = strb.pc_oe;
  assign pc_ie    = strb.pc_ie;
  assign mar_ie   = strb.mar_ie;
  assign mdr_oe   = strb.mdr_oe;
  assign ir_oe    = strb.ir_oe;
  assign ir_ie    = strb.ir_ie;
  assign z_oe     = strb.z_oe;
  assign z_ie     = strb.z_ie;
  assign r1_ie    = strb.r1_ie;
  assign alu_inc  = strb.alu_inc;
  assign mem_rd   = strb.mem_rd;
  assign end_step = strb.end_step;

  AST_STALL_HOLDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((step == ST_PC_WB || step == ST_OPND_WAIT) && !mem_done) |=> $stable(step)); // R10

  AST_IR_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ie |=> (step == ST_DECODE)); // R4

  AST_FETCH_STEP_READS: assert property (@(posedge clk) disable iff (!rst_n)
    pc_oe |-> (mem_rd && mar_ie && z_ie && alu_inc)); // R2

endmodule

// File: tb/test_fetch_step_ctrl.sv
module test_fetch_step_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mem_done = 1'b0;
  logic [7:0] pc, mar, mdr, ir, z, r1, bus;
  logic [7:0] mem [16];
  int         lat_cfg = 0;
  int         pend_cnt = 0;
  logic       pend = 1'b0;
  int         checks = 0;
  int         errors = 0;
  int         conflicts = 0;
  logic       pc_oe, pc_ie, mar_ie, mdr_oe, ir_oe, ir_ie, z_oe, z_ie;
  logic       r1_ie, alu_inc, mem_rd, end_step;
  logic [11:0] sv;

  localparam logic [11:0] V_FETCH = 12'b1010_0001_0110;
  localparam logic [11:0] V_PCWB  = 12'b0100_0010_0000;
  localparam logic [11:0] V_IRLD  = 12'b0001_0100_0000;
  localparam logic [11:0] V_LDDEC = 12'b0010_1000_0010;
  localparam logic [11:0] V_UNK   = 12'b0000_0000_0001;
  localparam logic [11:0] V_R1LD  = 12'b0001_0000_1001;
  localparam logic [11:0] V_NONE  = 12'b0000_0000_0000;

  always #5 clk = ~clk;

  fetch_step_ctrl i_fetch_step_ctrl (
    .clk(clk), .rst_n(rst_n), .mem_done(mem_done), .opcode(ir[7:4]),
    .pc_oe(pc_oe), .pc_ie(pc_ie), .mar_ie(mar_ie), .mdr_oe(mdr_oe),
    .ir_oe(ir_oe), .ir_ie(ir_ie), .z_oe(z_oe), .z_ie(z_ie), .r1_ie(r1_ie),
    .alu_inc(alu_inc), .mem_rd(mem_rd), .end_step(end_step)
  );

  assign sv = {pc_oe, pc_ie, mar_ie, mdr_oe, ir_oe, ir_ie, z_oe, z_ie,
               r1_ie, alu_inc, mem_rd, end_step};

  always_comb begin
    bus = 8'h00;
    if (pc_oe)  bus = pc;
    if (z_oe)   bus = z;
    if (mdr_oe) bus = mdr;
    if (ir_oe)  bus = {4'h0, ir[3:0]};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; mar <= '0; z <= '0; ir <= '0; r1 <= '0;
    end else begin
      if (mar_ie) mar <= bus;
      if (z_ie)   z   <= alu_inc ? bus + 8'd1 : bus;
      if (pc_ie)  pc  <= bus;
      if (ir_ie)  ir  <= bus;
      if (r1_ie)  r1  <= bus;
    end
  end

  always @(negedge clk) begin
    if (($countones({pc_oe, z_oe, mdr_oe, ir_oe}) > 1) && rst_n) conflicts++;
    if (!rst_n) begin
      pend = 1'b0; mem_done = 1'b0; mdr = 8'h00;
    end else if (pend) begin
      if (pend_cnt == 0) begin
        mem_done = 1'b1; mdr = mem[mar[3:0]]; pend = 1'b0;
      end else begin
        pend_cnt--;
      end
    end else begin
      mem_done = 1'b0;
      if (mem_rd) begin pend = 1'b1; pend_cnt = lat_cfg; end
    end
  end

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_chk(input string req, input logic [11:0] exp);
    @(negedge clk); #2;
    chk(req, sv, exp);
  endtask

  task automatic data_chk(input string req, input logic [7:0] exp_pc, input logic [7:0] exp_r1);
    @(posedge clk); #1;
    chk({req, " pc"}, {4'h0, pc}, {4'h0, exp_pc});
    chk({req, " r1"}, {4'h0, r1}, {4'h0, exp_r1});
  endtask

  task automatic t_reset();
    repeat (3) begin
      @(negedge clk); #2;
      chk("R1 in reset", sv, V_NONE);
    end
    rst_n = 1'b1;
    #1 chk("R1 idle after release", sv, V_NONE);
  endtask

  // Direct load with latency lat: 6 + 2*lat cycles (R11)
  task automatic t_load(input int lat, input logic [7:0] exp_pc, input logic [7:0] exp_r1);
    lat_cfg = lat;
    step_chk("R2 fetch", V_FETCH);
    for (int i = 0; i < lat; i++) step_chk("R10 stall pc write-back", V_NONE);
    step_chk("R3 pc write-back", V_PCWB);
    step_chk("R4 ir load", V_IRLD);
    step_chk("R5 load decode", V_LDDEC);
    for (int i = 0; i < lat; i++) step_chk("R10 stall operand", V_NONE);
    step_chk("R6 operand wait", V_NONE);
    step_chk("R6 r1 load end R11", V_R1LD);
    data_chk("R6 load result", exp_pc, exp_r1);
  endtask

  task automatic t_unknown(input int lat, input logic [7:0] exp_pc, input logic [7:0] exp_r1);
    lat_cfg = lat;
    step_chk("R8 fetch after end", V_FETCH);
    for (int i = 0; i < lat; i++) step_chk("R10 stall", V_NONE);
    step_chk("R3 pc write-back", V_PCWB);
    step_chk("R4 ir load", V_IRLD);
    step_chk("R7 unknown opcode end R11", V_UNK);
    data_chk("R7 r1 untouched", exp_pc, exp_r1);
  endtask

  task automatic t_mid_reset();
    lat_cfg = 3;
    step_chk("R2 fetch", V_FETCH);
    step_chk("R10 stall", V_NONE);
    @(negedge clk); rst_n = 1'b0; #2;
    chk("R1 reset mid stall", sv, V_NONE);
    @(negedge clk); #2;
    chk("R1 held in reset", sv, V_NONE);
    rst_n = 1'b1;
    #1 chk("R1 idle after release", sv, V_NONE);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 37 + 5);
    mem[0]  = 8'h1A;
    mem[1]  = 8'h7F;
    mem[2]  = 8'h1C;
    mem[10] = 8'h5A;
    mem[12] = 8'hC3;
    t_reset();
    t_load(0, 8'd1, 8'h5A);
    t_unknown(1, 8'd2, 8'h5A);
    t_load(3, 8'd3, 8'hC3);
    t_mid_reset();
    t_load(1, 8'd1, 8'h5A);
    checks++;
    if (conflicts != 0) begin
      errors++;
      $display("FAIL R9 bus conflicts actual=%0d expected=0", conflicts);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule